// File: doc/BRIEF.md
# Shared-Bus Burst Host Port

This block is the slave side of a synchronous host port. An external processor reaches a 16-bit word memory, or a small register file, through one shared address/data bus. A transfer opens with an address phase: chip select is low and a one-clock latch pulse is given. The block captures the start address and the target space at that pulse.

On the next clock, a one-clock active-low strobe starts a sequential burst and fixes its direction. From then on the block moves one word on every rising edge while its active-low ready output is low. The address steps by one after each word. The host marks the final word with an active-low last flag. Raising chip select early ends the burst.

Words are moved only while both byte-lane enables are set. A violation sets a sticky error flag. The flag blocks writes and forces read data to zero until chip select rises. A separate active-low stop output reports, one clock late, that an internal command queue is full.

Top module: `mux_burst_host_if`

## Requirements
- R1: An edge with `cs_n` low and `alat` high, in the idle state, captures `ad_in[5:0]` as the start address and `mem_sel` as the target space (1 = memory array of 64 words, 0 = register file of 8 words). An `alat` pulse with `cs_n` high is ignored.
- R2: A burst starts only if `strb_n` is low with `cs_n` low at the edge right after the latch edge. `rnw` is sampled at that edge (1 = read, 0 = write). At any other time a strobe is ignored and the block returns to idle.
- R3: `rdy_n` goes low in the cycle after the strobe edge and stays low until the burst ends. Every rising edge with `rdy_n` low and `cs_n` low transfers one word.
- R4: The word address starts at the latched value and steps by one after each transferred word, wrapping modulo 64. The register file is indexed by the low three address bits.
- R5: The edge where `last_n` is low transfers the final word, and `rdy_n` is high after that edge.
- R6: An edge with `cs_n` high during a burst ends it without transferring a word, and `rdy_n` is high after it.
- R7: `wen` must be binary 11 at each transfer edge. Otherwise `err` is set at that edge and holds while `cs_n` stays low, and it clears at the first edge with `cs_n` high. No word is written at an edge with a bad `wen` or while `err` is set.
- R8: `stop_n` equals the inverse of `cmdq_full` at the previous edge, and it is high after reset.
- R9: During a read burst, while `cs_n` is low, `ad_oe` is high and `ad_out` carries the word at the current address. `ad_out` is zero while `err` is set, while `wen` is not 11, and whenever `ad_oe` is low.
- R10: After reset, `rdy_n` and `stop_n` are high, `err` and `ad_oe` are low, and every storage word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| alat | input | 1 | Address latch pulse |
| strb_n | input | 1 | Active-low burst start strobe |
| rnw | input | 1 | Direction, 1 = read |
| mem_sel | input | 1 | Target space, 1 = memory array |
| wen | input | 2 | Byte-lane enables, must be 11 |
| last_n | input | 1 | Active-low final-word flag |
| ad_in | input | 16 | Shared bus, inbound (address or write data) |
| ad_out | output | 16 | Shared bus, outbound read data |
| ad_oe | output | 1 | Drive enable for the outbound bus |
| rdy_n | output | 1 | Active-low ready |
| err | output | 1 | Sticky lane-enable violation flag |
| cmdq_full | input | 1 | Internal command queue full |
| stop_n | output | 1 | Active-low stop / backpressure |

## Verification
The bench targets these corner cases:
- A strobe that comes one clock late. A design that waited for it would start a burst it should have refused.
- A latch pulse given while chip select is high. A design that honoured it would move words into an unintended space.
- Bursts that cross the top of the memory and of the register file. A design that carried the address into a wider counter, or indexed the register file wrongly, would read back the wrong words.
- A lane-enable violation in the middle of a burst. A design whose flag was not sticky would keep writing after the bad word, and one that never cleared the flag would zero every later read.
- Chip select rising before the last word. A design that counted that edge as a transfer would write or skip one word too many.

// File: rtl/mbh_pkg.sv
package mbh_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_BURST = 2'd2
   } mbh_state_e;
endpackage

// File: rtl/mbh_addr_ctr.sv
module mbh_addr_ctr #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] addr
);
   initial assert (AW >= 1) else $error("mbh_addr_ctr: AW must be at least 1");

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (inc)  addr <= addr + 1'b1;
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> (addr == $past(addr) + 1'b1)) else $error("address step"); // R4
endmodule

// File: rtl/mbh_store.sv
module mbh_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   initial assert (DEPTH >= 2 && (1 << AW) == DEPTH)
      else $error("mbh_store: DEPTH must be a power of two, at least 2");

   logic [DW-1:0] q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      end else if (we) begin
         q[addr] <= wdata;
      end
   end

   assign rdata = q[addr];
endmodule

// File: rtl/mbh_ctrl.sv
module mbh_ctrl
   import mbh_pkg::*;
#(
   parameter int WEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             alat,
   input  logic             strb_n,
   input  logic             last_n,
   input  logic             rnw,
   input  logic             mem_sel,
   input  logic [WEN_W-1:0] wen,
   output mbh_state_e       state,
   output logic             load,
   output logic             xfer,
   output logic             dir_rd,
   output logic             space_mem,
   output logic             wen_ok,
   output logic             err
);
   initial assert (WEN_W >= 1) else $error("mbh_ctrl: WEN_W must be at least 1");

   assign load   = (state == ST_IDLE) && !cs_n && alat;
   assign xfer   = (state == ST_BURST) && !cs_n;
   assign wen_ok = &wen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         dir_rd    <= 1'b0;
         space_mem <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (load) begin
                  state     <= ST_ARMED;
                  space_mem <= mem_sel;
               end
            end
            ST_ARMED: begin
               if (!cs_n && !strb_n) begin
                  state  <= ST_BURST;
                  dir_rd <= rnw;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_BURST: begin
               if (cs_n || !last_n) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                err <= 1'b0;
      else if (cs_n)             err <= 1'b0;
      else if (xfer && !wen_ok)  err <= 1'b1;
   end

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !cs_n) |=> err) else $error("error flag dropped"); // R7
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !err) else $error("error flag kept"); // R7
   AST_BURST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (state != ST_BURST)) else $error("burst without latch"); // R2
endmodule

// File: rtl/mux_burst_host_if.sv
module mux_burst_host_if
   import mbh_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int MEM_DEPTH = 64,
   parameter int REG_DEPTH = 8,
   parameter int WEN_W     = 2,
   parameter bit STOP_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              alat,
   input  logic              strb_n,
   input  logic              rnw,
   input  logic              mem_sel,
   input  logic [WEN_W-1:0]  wen,
   input  logic              last_n,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic              rdy_n,
   output logic              err,
   input  logic              cmdq_full,
   output logic              stop_n
);
   localparam int MEM_AW = $clog2(MEM_DEPTH);
   localparam int REG_AW = $clog2(REG_DEPTH);

   initial begin
      assert (MEM_AW <= DATA_W) else $error("address wider than the bus");
      assert (REG_DEPTH <= MEM_DEPTH) else $error("register file deeper than memory");
   end

   mbh_state_e        state;
   logic              load, xfer, dir_rd, space_mem, wen_ok;
   logic [MEM_AW-1:0] addr;
   logic [DATA_W-1:0] mem_rd, reg_rd, sel_rd;
   logic              wr_ok, mem_we, reg_we;

   mbh_ctrl #(.WEN_W(WEN_W)) u_ctrl (
      .clk, .rst_n, .cs_n, .alat, .strb_n, .last_n, .rnw, .mem_sel, .wen,
      .state, .load, .xfer, .dir_rd, .space_mem, .wen_ok, .err
   );

   mbh_addr_ctr #(.AW(MEM_AW)) u_addr (
      .clk, .rst_n, .load,
      .load_val (ad_in[MEM_AW-1:0]),
      .inc      (xfer),
      .addr
   );

   assign wr_ok  = xfer && !dir_rd && wen_ok && !err;
   assign mem_we = wr_ok && space_mem;
   assign reg_we = wr_ok && !space_mem;

   mbh_store #(.DEPTH(MEM_DEPTH), .DW(DATA_W)) u_mem (
      .clk, .rst_n, .we(mem_we), .addr(addr), .wdata(ad_in), .rdata(mem_rd)
   );

   mbh_store #(.DEPTH(REG_DEPTH), .DW(DATA_W)) u_regs (
      .clk, .rst_n, .we(reg_we), .addr(addr[REG_AW-1:0]), .wdata(ad_in), .rdata(reg_rd)
   );

   assign sel_rd = space_mem ? mem_rd : reg_rd;
   assign ad_oe  = xfer && dir_rd;
   assign ad_out = (ad_oe && wen_ok && !err) ? sel_rd : '0;
   assign rdy_n  = (state != ST_BURST);

   generate
      if (STOP_REG) begin : g_stop_reg
         logic stop_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stop_q <= 1'b1;
            else        stop_q <= !cmdq_full;
         end
         assign stop_n = stop_q;

         AST_STOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            cmdq_full |=> !stop_n) else $error("stop not raised"); // R8
      end else begin : g_stop_comb
         assign stop_n = !cmdq_full;
      end
   endgenerate

   AST_RDY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> $past(!strb_n && !cs_n)) else $error("ready without strobe"); // R2
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && !last_n) |=> rdy_n) else $error("ready after last"); // R5
   AST_CS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && cs_n) |=> rdy_n) else $error("ready after deselect"); // R6
   AST_NO_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || reg_we) |-> (&wen && !err)) else $error("write with bad enables"); // R7
   AST_OE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!rdy_n && !cs_n)) else $error("bus driven outside burst"); // R9
endmodule

// File: tb/tb_mux_burst_host_if.sv
module tb_mux_burst_host_if;
   localparam int MDEP = 64;
   localparam int RDEP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, alat = 1'b0, strb_n = 1'b1, rnw = 1'b0, mem_sel = 1'b1;
   logic [1:0]  wen = 2'b11;
   logic        last_n = 1'b1;
   logic [15:0] ad_in = '0;
   logic [15:0] ad_out;
   logic        ad_oe, rdy_n, err, stop_n;
   logic        cmdq_full = 1'b0;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mux_burst_host_if dut (
      .clk, .rst_n, .cs_n, .alat, .strb_n, .rnw, .mem_sel, .wen, .last_n,
      .ad_in, .ad_out, .ad_oe, .rdy_n, .err, .cmdq_full, .stop_n
   );

   // behavioural reference model
   logic [15:0] m_mem [MDEP];
   logic [15:0] m_reg [RDEP];
   int m_st;           // 0 idle, 1 armed, 2 burst
   int m_addr;
   bit m_space, m_dir, m_err, m_stop;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MDEP; i++) m_mem[i] = '0;
         for (int i = 0; i < RDEP; i++) m_reg[i] = '0;
         m_st = 0; m_addr = 0; m_space = 1; m_dir = 0; m_err = 0; m_stop = 1;
      end else begin
         bit nerr;
         nerr = m_err;
         if (cs_n) nerr = 0;
         case (m_st)
            0: if (!cs_n && alat) begin
                  m_addr = int'(ad_in) % MDEP; m_space = mem_sel; m_st = 1;
               end
            1: if (!cs_n && !strb_n) begin m_dir = rnw; m_st = 2; end
               else m_st = 0;
            default: begin
               if (cs_n) m_st = 0;
               else begin
                  if (wen != 2'b11) nerr = 1;
                  if (!m_dir && wen == 2'b11 && !m_err) begin
                     if (m_space) m_mem[m_addr] = ad_in;
                     else         m_reg[m_addr % RDEP] = ad_in;
                  end
                  m_addr = (m_addr + 1) % MDEP;
                  if (!last_n) m_st = 0;
               end
            end
         endcase
         m_err  = nerr;
         m_stop = !cmdq_full;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   // compare every cycle, mid-period
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic        e_oe;
         logic [15:0] e_out;
         e_oe  = (m_st == 2) && m_dir && !cs_n;
         e_out = '0;
         if (e_oe && !m_err && wen == 2'b11)
            e_out = m_space ? m_mem[m_addr] : m_reg[m_addr % RDEP];
         chk("R3 rdy_n", 32'(rdy_n), 32'(m_st != 2));
         chk("R9 ad_oe", 32'(ad_oe), 32'(e_oe));
         chk("R9 ad_out (R1 R4 R2 R5 R6 path)", 32'(ad_out), 32'(e_out));
         chk("R7 err", 32'(err), 32'(m_err));
         chk("R8 stop_n", 32'(stop_n), 32'(m_stop));
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic burst(input int addr, input bit mem, input bit rd, input int n,
                        input int bad_at, input int abort_at, input logic [15:0] base);
      step(); cs_n = 1'b0; alat = 1'b1; ad_in = 16'(addr); mem_sel = mem;
      step(); alat = 1'b0; strb_n = 1'b0; rnw = rd; ad_in = '0;
      step(); strb_n = 1'b1;
      for (int i = 0; i < n; i++) begin
         if (i == abort_at) begin cs_n = 1'b1; step(); break; end
         ad_in  = rd ? 16'h0 : 16'(base + 16'(i));
         last_n = (i == n - 1) ? 1'b0 : 1'b1;
         wen    = (i == bad_at) ? 2'b01 : 2'b11;
         step();
      end
      cs_n = 1'b1; last_n = 1'b1; wen = 2'b11; ad_in = '0;
      step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset values
      chk("R10 rdy_n", 32'(rdy_n), 32'd1);
      chk("R10 stop_n", 32'(stop_n), 32'd1);
      chk("R10 err", 32'(err), 32'd0);
      chk("R10 ad_oe", 32'(ad_oe), 32'd0);
      step(); rst_n = 1'b1;
      step();

      // R1 R3 R5: write then read four memory words
      burst(5, 1, 0, 4, -1, -1, 16'hA100);
      burst(5, 1, 1, 4, -1, -1, 16'h0);
      // R4: register file wraps via low address bits
      burst(6, 0, 0, 4, -1, -1, 16'hB200);
      burst(0, 0, 1, 8, -1, -1, 16'h0);
      // R4: memory wraps modulo 64
      burst(62, 1, 0, 3, -1, -1, 16'hC300);
      burst(62, 1, 1, 3, -1, -1, 16'h0);
      burst(0, 1, 1, 2, -1, -1, 16'h0);

      // R1: latch pulse with chip select high is ignored
      step(); cs_n = 1'b1; alat = 1'b1; ad_in = 16'd40;
      step(); alat = 1'b0; cs_n = 1'b0; strb_n = 1'b0;
      step(); strb_n = 1'b1; cs_n = 1'b1;
      step(); chk("R1 no burst after ignored latch", 32'(rdy_n), 32'd1);

      // R2: strobe one clock late is ignored
      step(); cs_n = 1'b0; alat = 1'b1; ad_in = 16'd9;
      step(); alat = 1'b0;
      step(); strb_n = 1'b0;
      step(); strb_n = 1'b1;
      step(); chk("R2 late strobe refused", 32'(rdy_n), 32'd1);
      cs_n = 1'b1;

      // R6: chip select rises before last word
      burst(30, 1, 0, 5, -1, 2, 16'hD400);
      burst(30, 1, 1, 5, -1, -1, 16'h0);

      // R7: bad enables mid write, then mid read
      burst(20, 1, 0, 4, 1, -1, 16'hE500);
      burst(20, 1, 1, 4, 2, -1, 16'h0);
      burst(20, 1, 1, 4, -1, -1, 16'h0);

      // R8: queue full toggling, also inside a burst
      step(); cmdq_full = 1'b1;
      step(); step(); cmdq_full = 1'b0;
      step(); cmdq_full = 1'b1;
      burst(3, 0, 1, 3, -1, -1, 16'h0);
      cmdq_full = 1'b0;
      step(); step();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule